// File: doc/BRIEF.md
# Radix Page Table Walker

The walker turns a 64-bit effective address into a real address by reading a multi-level radix tree from memory, one doubleword at a time. A request carries the address, an access kind (load, store or instruction fetch) and a privilege flag. The process-table base and the process ID are taken from two register inputs. The walker first forms the address of the process-table entry and reads it. That entry gives the tree size, the root size and the root base. The walker then checks that the address lies inside the tree and visits one directory level per read until it reaches a leaf.

Each directory entry sets the width of the next index through its own size field. A shift counter, held per walk, tracks how many address bits remain to be consumed. Table addresses are built by merging base bits with address bits under a thermometer mask. They are not built by slicing at fixed positions. On a valid leaf the walker checks the access rights and the reference/change bits. It then returns the merged real address and the leaf entry. Every walk ends with a single-cycle completion pulse that carries an error code.

Top module: `radix_walker`

## Requirements
- R1: After reset, and after a reset applied in the middle of a walk, `busy`, `done` and `mem_req` are low and `err_code` is 0. The next request is walked normally.
- R2: The process-table entry address is {8'b0, pt_base[55:36], (pt_base[35:12] & ~M) | (pid[31:8] & M), pid[7:0], 4'b0}. Here M holds the low pt_base[4:0] bits set.
- R3: When req_addr[63] is 1, the PID used in R2 is zero. Otherwise it is proc_id.
- R4: The tree size is {entry[62:61], entry[7:5]} of the process-table entry. The walk ends with code 3 (segment) when address bit 63 differs from bit 62, or when any address bit 61..31 lies above the low tree-size bits. Bits 31..(30+size) are allowed.
- R5: The root size is entry[4:0] of the process-table entry and must lie in 5..16 and be at most tree size + 19. The size entry[4:0] of a non-leaf entry must lie in 5..16 and be at most the remaining shift. A violation ends the walk with code 2 (bad tree).
- R6: Each table read is a one-cycle `mem_req` with a doubleword-aligned `mem_addr`. The walker waits for `mem_rvalid` before it uses the data. A level address is {8'b0, base[55:19], (base[18:3] & ~K) | (index & K), 3'b0}. Here K holds the low size bits set, and the index is effective-address bits from 12 + shift upward.
- R7: A read entry with bit 63 (valid) clear ends the walk with code 1 (invalid).
- R8: An entry with bits 63 and 62 set is a leaf. On success (code 0) `real_addr` = {8'b0, (leaf[55:12] & ~F) | (addr[55:12] & F), leaf[11:0]}, where F holds the low remaining-shift bits set. `leaf_pte` returns the leaf.
- R9: Permission in the leaf uses bit 0 (execute), bit 1 (read/write), bit 2 (read), bit 3 (privileged only) and bit 5 (inhibited). Unprivileged access to a bit-3 page fails. A fetch needs bit 0 set and bit 5 clear. A load needs bit 1 or bit 2. A store needs bit 1. A failure gives code 4 (permission).
- R10: With permission granted, the leaf needs bit 8 (referenced), and a store also needs bit 7 (changed). Otherwise the code is 5 (ref/change). A permission failure takes precedence over a ref/change failure.
- R11: `done` is high for exactly one cycle per walk. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | start a walk (accepted only when idle) |
| req_addr | input | 64 | effective address |
| req_store | input | 1 | access is a store |
| req_fetch | input | 1 | access is an instruction fetch |
| req_priv | input | 1 | access is privileged |
| pt_base | input | 64 | process-table base and size register |
| proc_id | input | 32 | process ID |
| busy | output | 1 | walk in progress |
| mem_req | output | 1 | one-cycle read request |
| mem_addr | output | 64 | read address |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | 64 | read data |
| done | output | 1 | one-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 invalid, 2 bad tree, 3 segment, 4 permission, 5 ref/change |
| real_addr | output | 64 | translated address |
| leaf_pte | output | 64 | last entry read |

## Verification
The assertions assume that `mem_rvalid` arrives only after a request and only once for each request. They also assume that `pt_base` and `proc_id` stay constant while a walk is in flight. The bench memory model answers each read exactly once, two cycles after the request, and returns zero for any unmapped address. The bench changes `pt_base` and `proc_id` only between walks. Stray request pulses are driven only while the walker is busy, which exercises the rule that such requests are ignored.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_INVALID = 3'd1,
    E_BADTREE = 3'd2,
    E_SEGMENT = 3'd3,
    E_PERM    = 3'd4,
    E_RC      = 3'd5
  } walk_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRT_REQ, S_PRT_WAIT, S_SEG, S_LK_REQ, S_LK_WAIT, S_FIN
  } walk_state_e;

  localparam int MASK_W = 44;

  // thermometer mask: the low n bits are set
  function automatic logic [MASK_W-1:0] thermo(input logic [5:0] n);
    logic [MASK_W-1:0] m;
    for (int i = 0; i < MASK_W; i++) m[i] = (32'(i) < {26'd0, n});
    return m;
  endfunction

endpackage

// File: rtl/radix_addr_gen.sv
module radix_addr_gen
  import radix_walk_pkg::*;
(
  input  logic [63:0] pt_base,
  input  logic [31:0] eff_pid,
  input  logic [63:0] va,
  input  logic [63:0] pgbase,
  input  logic [4:0]  idx_bits,
  input  logic [5:0]  shift,
  input  logic [63:0] leaf,
  output logic [63:0] prt_addr,
  output logic [63:0] lvl_addr,
  output logic [63:0] real_addr
);
  logic [MASK_W-1:0] pm_full, km_full, fm;
  logic [23:0] pm;
  logic [15:0] km, idx16;
  logic [51:0] va_sh;

  always_comb begin
    pm_full  = thermo({1'b0, pt_base[4:0]});
    pm       = pm_full[23:0];
    prt_addr = {8'd0, pt_base[55:36],
                (pt_base[35:12] & ~pm) | (eff_pid[31:8] & pm),
                eff_pid[7:0], 4'd0};

    km_full  = thermo({1'b0, idx_bits});
    km       = km_full[15:0];
    va_sh    = va[63:12] >> shift;
    idx16    = va_sh[15:0];
    lvl_addr = {8'd0, pgbase[55:19], (pgbase[18:3] & ~km) | (idx16 & km), 3'd0};

    fm        = thermo(shift);
    real_addr = {8'd0, (leaf[55:12] & ~fm) | (va[55:12] & fm), leaf[11:0]};
  end
endmodule

// File: rtl/radix_entry_check.sv
module radix_entry_check
  import radix_walk_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 16
) (
  input  logic [63:0] entry,
  input  logic [6:0]  limit,
  input  logic [63:0] va,
  input  logic [5:0]  tree_size,
  input  logic        is_store,
  input  logic        is_fetch,
  input  logic        is_priv,
  output logic        size_ok,
  output logic        seg_ok,
  output logic        perm_ok,
  output logic        rc_ok
);
  localparam logic [4:0] MIN_L = 5'(MIN_BITS);
  localparam logic [4:0] MAX_L = 5'(MAX_BITS);

  logic [4:0] sz;
  logic [MASK_W-1:0] tm;

  always_comb begin
    sz      = entry[4:0];
    size_ok = (sz >= MIN_L) && (sz <= MAX_L) && ({2'b00, sz} <= limit);

    tm     = thermo(tree_size);
    seg_ok = (va[63] == va[62]) && ((va[61:31] & ~tm[30:0]) == 31'd0);

    perm_ok = 1'b0;
    if (is_priv || !entry[3]) begin
      if (is_fetch) perm_ok = entry[0] & ~entry[5];
      else          perm_ok = entry[1] | (entry[2] & ~is_store);
    end
    rc_ok = entry[8] & (entry[7] | ~is_store);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int SEG_ADJ  = 19,
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic        req_store,
  input  logic        req_fetch,
  input  logic        req_priv,
  input  logic [63:0] pt_base,
  input  logic [31:0] proc_id,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic [2:0]  err_code,
  output logic [63:0] real_addr,
  output logic [63:0] leaf_pte
);
  localparam logic [6:0] ADJ7 = 7'(SEG_ADJ);
  localparam logic [5:0] ADJ6 = 6'(SEG_ADJ);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  walk_state_e state_q, state_d;
  walk_err_e   err_q, err_d;
  logic [63:0] va_q, va_d, pgbase_q, pgbase_d, real_q, real_d, leaf_q, leaf_d;
  logic [5:0]  shift_q, shift_d;
  logic [4:0]  mbits_q, mbits_d;
  logic        st_q, st_d, fe_q, fe_d, pv_q, pv_d;

  logic [63:0] prt_addr, lvl_addr, leaf_real, chk_entry;
  logic [31:0] eff_pid;
  logic [6:0]  chk_limit;
  logic        size_ok, seg_ok, perm_ok, rc_ok;

  assign eff_pid   = va_q[63] ? 32'd0 : proc_id;
  assign chk_entry = (state_q == S_SEG) ? {59'd0, mbits_q} : mem_rdata;
  assign chk_limit = (state_q == S_SEG) ? ({1'b0, shift_q} + ADJ7) : {1'b0, shift_q};

  radix_addr_gen u_addr (
    .pt_base(pt_base), .eff_pid(eff_pid), .va(va_q), .pgbase(pgbase_q),
    .idx_bits(mbits_q), .shift(shift_q), .leaf(mem_rdata),
    .prt_addr(prt_addr), .lvl_addr(lvl_addr), .real_addr(leaf_real)
  );

  radix_entry_check #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_chk (
    .entry(chk_entry), .limit(chk_limit), .va(va_q), .tree_size(shift_q),
    .is_store(st_q), .is_fetch(fe_q), .is_priv(pv_q),
    .size_ok(size_ok), .seg_ok(seg_ok), .perm_ok(perm_ok), .rc_ok(rc_ok)
  );

  always_comb begin
    state_d = state_q; err_d = err_q; va_d = va_q; pgbase_d = pgbase_q;
    real_d = real_q; leaf_d = leaf_q; shift_d = shift_q; mbits_d = mbits_q;
    st_d = st_q; fe_d = fe_q; pv_d = pv_q;
    case (state_q)
      S_IDLE: if (req_valid) begin
        va_d = req_addr; st_d = req_store; fe_d = req_fetch; pv_d = req_priv;
        err_d = E_NONE; real_d = 64'd0; state_d = S_PRT_REQ;
      end
      S_PRT_REQ: state_d = S_PRT_WAIT;
      S_PRT_WAIT: if (mem_rvalid) begin
        shift_d  = {1'b0, mem_rdata[62:61], mem_rdata[7:5]};
        mbits_d  = mem_rdata[4:0];
        pgbase_d = {8'd0, mem_rdata[55:8], 8'd0};
        state_d  = S_SEG;
      end
      S_SEG: begin
        if (!seg_ok) begin
          err_d = E_SEGMENT; state_d = S_FIN;
        end else if (!size_ok) begin
          err_d = E_BADTREE; state_d = S_FIN;
        end else begin
          shift_d = shift_q + ADJ6 - {1'b0, mbits_q};
          state_d = S_LK_REQ;
        end
      end
      S_LK_REQ: state_d = S_LK_WAIT;
      S_LK_WAIT: if (mem_rvalid) begin
        leaf_d = mem_rdata;
        if (!mem_rdata[63]) begin
          err_d = E_INVALID; state_d = S_FIN;
        end else if (mem_rdata[62]) begin
          if (!perm_ok)    err_d = E_PERM;
          else if (!rc_ok) err_d = E_RC;
          else begin
            err_d = E_NONE; real_d = leaf_real;
          end
          state_d = S_FIN;
        end else if (!size_ok) begin
          err_d = E_BADTREE; state_d = S_FIN;
        end else begin
          shift_d  = shift_q - {1'b0, mem_rdata[4:0]};
          mbits_d  = mem_rdata[4:0];
          pgbase_d = {8'd0, mem_rdata[55:8], 8'd0};
          state_d  = S_LK_REQ;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= S_IDLE; err_q <= E_NONE; va_q <= '0; pgbase_q <= '0;
      real_q <= '0; leaf_q <= '0; shift_q <= '0; mbits_q <= '0;
      st_q <= 1'b0; fe_q <= 1'b0; pv_q <= 1'b0;
    end else begin
      state_q <= state_d; err_q <= err_d; va_q <= va_d; pgbase_q <= pgbase_d;
      real_q <= real_d; leaf_q <= leaf_d; shift_q <= shift_d; mbits_q <= mbits_d;
      st_q <= st_d; fe_q <= fe_d; pv_q <= pv_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign mem_req   = (state_q == S_PRT_REQ) || (state_q == S_LK_REQ);
  assign mem_addr  = (state_q == S_PRT_REQ) ? prt_addr : lvl_addr;
  assign done      = (state_q == S_FIN);
  assign err_code  = err_q;
  assign real_addr = real_q;
  assign leaf_pte  = leaf_q;

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req |=> !mem_req);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != S_IDLE) |=> $stable(va_q));
  // R8
  leaf_ok_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && err_q == E_NONE) |-> (leaf_q[63] && leaf_q[62]));
  // R7
  inval_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && err_q == E_INVALID) |-> !leaf_q[63]);
  // R5
  shift_mono_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == S_LK_WAIT && mem_rvalid && mem_rdata[63] && !mem_rdata[62])
      |=> (shift_q <= $past(shift_q)));
endmodule

// File: tb/radix_walker_test.sv
module radix_walker_test;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_store, req_fetch, req_priv;
  logic [63:0] req_addr, pt_base;
  logic [31:0] proc_id;
  logic busy, mem_req, mem_rvalid, done;
  logic [63:0] mem_addr, mem_rdata, real_addr, leaf_pte;
  logic [2:0] err_code;

  always #2 clk = ~clk; // 250 MHz

  radix_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_store(req_store), .req_fetch(req_fetch), .req_priv(req_priv),
    .pt_base(pt_base), .proc_id(proc_id), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .err_code(err_code), .real_addr(real_addr), .leaf_pte(leaf_pte)
  );

  int n_run = 0, n_fail = 0, rd_cnt = 0;

  // memory image: 16 doublewords, anything else reads as zero
  logic [63:0] m_a [16];
  logic [63:0] m_d [16];
  initial begin
    m_a[0]  = 64'h100000; m_d[0]  = 64'h4000_0000_0020_00AD; // process entry
    m_a[1]  = 64'h101050; m_d[1]  = 64'h4000_0000_0020_00AD;
    m_a[2]  = 64'h200000; m_d[2]  = 64'h8000_0000_0030_0009;
    m_a[3]  = 64'h300000; m_d[3]  = 64'h8000_0000_0040_0009;
    m_a[4]  = 64'h300008; m_d[4]  = 64'hC000_0080_0000_0187;
    m_a[5]  = 64'h400000; m_d[5]  = 64'h8000_0000_0050_0009;
    m_a[6]  = 64'h400008; m_d[6]  = 64'hC000_0000_7000_0187;
    m_a[7]  = 64'h400018; m_d[7]  = 64'h8000_0000_0060_000A;
    m_a[8]  = 64'h400020; m_d[8]  = 64'h8000_0000_0060_0004;
    m_a[9]  = 64'h500000; m_d[9]  = 64'hC000_0000_0AB0_0187;
    m_a[10] = 64'h500008; m_d[10] = 64'hC000_0000_0AB1_0105;
    m_a[11] = 64'h500010; m_d[11] = 64'hC000_0000_0AB2_0106;
    m_a[12] = 64'h500018; m_d[12] = 64'hC000_0000_0AB3_018F;
    m_a[13] = 64'h500020; m_d[13] = 64'hC000_0000_0AB4_01A7;
    m_a[14] = 64'h500028; m_d[14] = 64'hC000_0000_0AB5_0000;
    m_a[15] = 64'hFFF000; m_d[15] = 64'h0;
  end

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int i = 0; i < 16; i++) if (m_a[i] == a) return m_d[i];
    return 64'd0;
  endfunction

  // responder: data two cycles after each request
  initial begin
    logic [63:0] pa;
    int dly;
    dly = 0; pa = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        rd_cnt++; pa = mem_addr; dly = 2;
      end else if (dly > 0) begin
        dly--;
        if (dly == 0) begin mem_rdata = lookup(pa); mem_rvalid = 1'b1; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [1:0] mode,
                      input logic pv, input logic [63:0] ptb, input logic [31:0] pid);
    @(negedge clk);
    rd_cnt = 0; pt_base = ptb; proc_id = pid;
    req_addr = va; req_store = (mode == 2'd1); req_fetch = (mode == 2'd2);
    req_priv = pv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // mode: 0 load, 1 store, 2 fetch
  typedef struct packed {
    logic [63:0] va; logic [1:0] mode; logic pv; logic [63:0] ptb;
    logic [31:0] pid; logic [2:0] err; logic [63:0] ra; logic [3:0] nrd;
  } vec_t;
  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{64'h0,                  2'd0, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h0AB0_0187,   4'd5}, // R8
    '{64'h1000,               2'd1, 1'b0, 64'h100000, 32'h0,   3'd4, 64'h0,           4'd5}, // R9
    '{64'h2000,               2'd1, 1'b0, 64'h100000, 32'h0,   3'd5, 64'h0,           4'd5}, // R10
    '{64'h2000,               2'd0, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h0AB2_0106,   4'd5}, // R10
    '{64'h3000,               2'd0, 1'b0, 64'h100000, 32'h0,   3'd4, 64'h0,           4'd5}, // R9
    '{64'h3000,               2'd0, 1'b1, 64'h100000, 32'h0,   3'd0, 64'h0AB3_018F,   4'd5}, // R9
    '{64'h4000,               2'd2, 1'b0, 64'h100000, 32'h0,   3'd4, 64'h0,           4'd5}, // R9
    '{64'h4000,               2'd0, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h0AB4_01A7,   4'd5}, // R9
    '{64'h0,                  2'd2, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h0AB0_0187,   4'd5}, // R9
    '{64'h5000,               2'd0, 1'b0, 64'h100000, 32'h0,   3'd4, 64'h0,           4'd5}, // R10
    '{64'h6345_6000,          2'd0, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h80_2345_6187, 4'd3}, // R6
    '{64'h21_5000,            2'd0, 1'b0, 64'h100000, 32'h0,   3'd0, 64'h7001_5187,   4'd4}, // R6
    '{64'h40_0000,            2'd0, 1'b0, 64'h100000, 32'h0,   3'd1, 64'h0,           4'd4}, // R7
    '{64'h60_0000,            2'd0, 1'b0, 64'h100000, 32'h0,   3'd2, 64'h0,           4'd4}, // R5
    '{64'h80_0000,            2'd0, 1'b0, 64'h100000, 32'h0,   3'd2, 64'h0,           4'd4}, // R5
    '{64'h0010_0000_0000_0000, 2'd0, 1'b0, 64'h100000, 32'h0,  3'd3, 64'h0,           4'd1}, // R4
    '{64'h8000_0000_0000_0000, 2'd0, 1'b0, 64'h100000, 32'h0,  3'd3, 64'h0,           4'd1}, // R4
    '{64'h0008_0000_0000_0000, 2'd0, 1'b0, 64'h100000, 32'h0,  3'd1, 64'h0,           4'd2}, // R4
    '{64'hC000_0000_0000_0000, 2'd0, 1'b0, 64'h100000, 32'h5,  3'd0, 64'h0AB0_0187,   4'd5}, // R3
    '{64'h0,                  2'd0, 1'b0, 64'h100000, 32'h5,   3'd2, 64'h0,           4'd1}, // R3
    '{64'h1000,               2'd0, 1'b0, 64'h100004, 32'h105, 3'd0, 64'h0AB1_0105,   4'd5}, // R2
    '{64'h1000,               2'd0, 1'b0, 64'h100000, 32'h105, 3'd2, 64'h0,           4'd1}  // R2
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rd_before;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_store = 1'b0;
    req_fetch = 1'b0; req_priv = 1'b0; pt_base = 64'h100000; proc_id = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && err_code == 3'd0, "R1 reset outputs",
        {60'd0, busy, done, mem_req, 1'b0}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      walk(VT[i].va, VT[i].mode, VT[i].pv, VT[i].ptb, VT[i].pid);
      chk(err_code == VT[i].err, $sformatf("vec%0d err R%0d", i, 11),
          {61'd0, err_code}, {61'd0, VT[i].err});
      if (VT[i].err == 3'd0)
        chk(real_addr == VT[i].ra, $sformatf("vec%0d real addr R8", i), real_addr, VT[i].ra);
      chk(rd_cnt == int'(VT[i].nrd), $sformatf("vec%0d read count R6", i),
          64'(rd_cnt), {60'd0, VT[i].nrd});
    end

    // R8 leaf entry returned
    walk(64'h21_5000, 2'd0, 1'b0, 64'h100000, 32'h0);
    chk(leaf_pte == 64'hC000_0000_7000_0187, "R8 leaf entry", leaf_pte, 64'hC000_0000_7000_0187);
    // R11 done lasts one cycle
    @(negedge clk);
    chk(!done, "R11 done pulse width", {63'd0, done}, 64'd0);

    // R11 request while busy is ignored
    @(negedge clk);
    rd_cnt = 0; req_addr = 64'h0; req_store = 1'b0; req_fetch = 1'b0;
    req_priv = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_addr = 64'h1000; req_store = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(err_code == 3'd0 && real_addr == 64'h0AB0_0187, "R11 busy request ignored",
        real_addr, 64'h0AB0_0187);
    rd_before = rd_cnt;
    repeat (10) @(negedge clk);
    chk(!busy && rd_cnt == rd_before, "R11 no second walk", 64'(rd_cnt), 64'(rd_before));

    // R1 reset during a walk
    walk(64'h0, 2'd0, 1'b0, 64'h100000, 32'h0);
    @(negedge clk);
    req_addr = 64'h21_5000; req_store = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !done && err_code == 3'd0, "R1 reset mid walk",
        {62'd0, busy, mem_req}, 64'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    walk(64'h2000, 2'd0, 1'b0, 64'h100000, 32'h0);
    chk(err_code == 3'd0 && real_addr == 64'h0AB2_0106, "R1 walk after reset",
        real_addr, 64'h0AB2_0106);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule